// File: doc/BRIEF.md
# Receive Event Status with Shared Read-Clear

This block keeps the sticky receive-event flags of a serial receiver and turns them into one interrupt line. Single-cycle event pulses arrive from the receive path: control or address character seen, programmed character match, break begin, break end, framing error, parity error and overrun. Each pulse latches its own flag, and the flag holds until software reads it away. A separate level input says whether the receive FIFO fill level sits above its threshold. That input drives a FIFO request bit, which software acknowledges by writing a zero to it.

Software sees the flags through two read views. The full status view is 32 bits wide. The line view is 5 bits wide and carries the break-begin, framing, parity and overrun flags plus a live data-ready bit. The four flags that both views carry are cleared by a read of either view. A read of the full view also clears the flags that only it carries. The FIFO request bit is never cleared by a read. Instead it reads as zero while a FIFO read strobe is active. An enable vector gates each status bit into a registered interrupt output.

Top module: `rx_event_status`

## Requirements
- R1: After reset, the full view, the line view and the interrupt output are all zero.
- R2: A pulse on an event input sets its flag in the full view on the next cycle, and the flag then stays set until a clearing read. The flag positions are: bit 7 control character, bit 6 programmed match, bit 5 break end, bit 4 break begin, bit 3 framing error, bit 2 parity error, bit 1 overrun.
- R3: In the cycle of a full-view read, the read data shows the flags as they stand. On the next cycle, full-view bits 7:1 are zero and line-view bits 4:1 are zero.
- R4: The line view holds bit 4 break begin, bit 3 framing, bit 2 parity, bit 1 overrun and bit 0 data-ready, where data-ready equals the FIFO non-empty input. A line-view read clears those four flags in both views and leaves full-view bits 7:5 unchanged.
- R5: An event pulse in the same cycle as a read that would clear its flag leaves that flag set on the next cycle.
- R6: Full-view bit 0 (the FIFO request) becomes set on the cycle after the above-threshold input rises. It becomes clear on the cycle after that input is low.
- R7: While the FIFO read strobe is high, full-view bit 0 reads zero and does not count toward the interrupt.
- R8: A write with data bit 0 at zero clears the FIFO request on the next cycle. The request then stays clear while the level input stays high, and sets again only on a new rise of that input. A rise in the same cycle as the acknowledge wins. A write with data bit 0 at one has no effect.
- R9: A full-view read does not clear the FIFO request, and a line-view read does not clear data-ready.
- R10: The interrupt output equals the OR of all enabled full-view bits 7:0 as they stood one cycle earlier, where enable bit n gates status bit n.
- R11: Full-view bits 31:8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ctrl_i | input | 1 | Control/address character pulse |
| ev_pmatch_i | input | 1 | Programmed character match pulse |
| ev_brk_end_i | input | 1 | Break end pulse |
| ev_brk_on_i | input | 1 | Break begin pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_ovr_i | input | 1 | Overrun pulse |
| fifo_above_i | input | 1 | FIFO level above threshold |
| fifo_nonempty_i | input | 1 | FIFO holds data |
| fifo_rd_i | input | 1 | FIFO read strobe |
| full_rd_i | input | 1 | Read of the full status view |
| line_rd_i | input | 1 | Read of the line view |
| ack_wr_i | input | 1 | Write strobe to the full status view |
| ack_wbit0_i | input | 1 | Write data bit 0 |
| irq_en_i | input | 8 | Per-bit interrupt enable |
| full_rdata_o | output | 32 | Full status view |
| line_rdata_o | output | 5 | Line view |
| irq_o | output | 1 | Registered interrupt |

## Verification
Each flag is visible in the read data, so a flag that is wrongly set or dropped shows in the very next comparison of either view. It also shows in the interrupt one cycle after that. A clear mask that is decoded wrongly leaves bits 7:5 or 4:1 in the wrong state on the cycle after a read. Broken edge tracking on the FIFO level makes bit 0 come back after an acknowledge, or fail to come back after a fresh rise, within one cycle. The bench predicts both views and the interrupt on every cycle, so any such state error is reported the cycle it reaches a port.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
    // Full status view: bit 0 is the FIFO request, bits 7:1 are event flags
    localparam int FLAG_W  = 8;
    localparam int EV_N    = FLAG_W - 1;
    // Line view: bit 0 data-ready, bits 4:1 mirror the shared flags
    localparam int LINE_W  = 5;
    localparam int SHR_TOP = LINE_W - 1;   // highest shared status bit

    // Status bit positions (software decodes these)
    localparam int B_FIFO    = 0;
    localparam int B_OVR     = 1;
    localparam int B_PARITY  = 2;
    localparam int B_FRAME   = 3;
    localparam int B_BRK_ON  = 4;
    localparam int B_BRK_END = 5;
    localparam int B_PMATCH  = 6;
    localparam int B_CTRL    = 7;

    typedef struct packed {
        logic [EV_N-1:0] flags;   // flags[k] is status bit k+1
    } flag_state_t;

    typedef struct packed {
        logic above;   // level seen last cycle
        logic req;     // FIFO request
    } freq_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/rx_evt_flags.sv
module rx_evt_flags
    import rx_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] evt_i,
    input  logic [EV_N-1:0] clr_i,
    output logic [EV_N-1:0] flags_o
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int k = 0; k < EV_N; k++) begin
            // set beats clear so that no event is lost
            state_d.flags[k] = evt_i[k] | (state_q.flags[k] & ~clr_i[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags_o = state_q.flags;

    for (genvar k = 0; k < EV_N; k++) begin : g_chk
        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> flags_o[k]);
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[k] && !clr_i[k]) |=> flags_o[k]);
        assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[k] && clr_i[k]) |=> flags_o[k]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !evt_i[k]) |=> !flags_o[k]);
    end
endmodule

// File: rtl/rx_fifo_req.sv
module rx_fifo_req
    import rx_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    input  logic fifo_rd_i,
    input  logic ack_i,
    output logic req_o
);
    freq_state_t state_d, state_q;
    logic        rise;

    always_comb begin
        state_d       = state_q;
        rise          = above_i & ~state_q.above;
        state_d.above = above_i;
        if (rise)
            state_d.req = 1'b1;
        else if (!above_i || ack_i)
            state_d.req = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_o = state_q.req & ~fifo_rd_i;

    assert_level_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !above_i |=> !state_q.req);
    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (above_i && !state_q.above) |=> state_q.req);
    assert_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.req && state_q.above) |=> !state_q.req);
    assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && state_q.above) |=> !state_q.req);
    assert_rd_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_i |-> !req_o);
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
    import rx_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] view_i,
    input  logic [FLAG_W-1:0] en_i,
    output logic              irq_o
);
    irq_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.irq = |(view_i & en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_o = state_q.irq;

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((view_i & en_i) == '0) |=> !irq_o);
    assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((view_i & en_i) != '0) |=> irq_o);
endmodule

// File: rtl/rx_event_status.sv
module rx_event_status
    import rx_evt_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ctrl_i,
    input  logic              ev_pmatch_i,
    input  logic              ev_brk_end_i,
    input  logic              ev_brk_on_i,
    input  logic              ev_frame_i,
    input  logic              ev_parity_i,
    input  logic              ev_ovr_i,
    input  logic              fifo_above_i,
    input  logic              fifo_nonempty_i,
    input  logic              fifo_rd_i,
    input  logic              full_rd_i,
    input  logic              line_rd_i,
    input  logic              ack_wr_i,
    input  logic              ack_wbit0_i,
    input  logic [FLAG_W-1:0] irq_en_i,
    output logic [REG_W-1:0]  full_rdata_o,
    output logic [LINE_W-1:0] line_rdata_o,
    output logic              irq_o
);
    localparam int RSV_W = REG_W - FLAG_W;

    logic [EV_N-1:0]   evt_vec;
    logic [EV_N-1:0]   clr_vec;
    logic [EV_N-1:0]   flags;
    logic              req_vis;
    logic              ack;
    logic [FLAG_W-1:0] view;

    // flags[k] carries status bit k+1
    always_comb begin
        evt_vec                = '0;
        evt_vec[B_OVR-1]       = ev_ovr_i;
        evt_vec[B_PARITY-1]    = ev_parity_i;
        evt_vec[B_FRAME-1]     = ev_frame_i;
        evt_vec[B_BRK_ON-1]    = ev_brk_on_i;
        evt_vec[B_BRK_END-1]   = ev_brk_end_i;
        evt_vec[B_PMATCH-1]    = ev_pmatch_i;
        evt_vec[B_CTRL-1]      = ev_ctrl_i;
    end

    // full read clears every flag; line read clears only the shared ones
    always_comb begin
        for (int k = 0; k < EV_N; k++) begin
            clr_vec[k] = full_rd_i | (line_rd_i & ((k + 1) <= SHR_TOP));
        end
    end

    assign ack = ack_wr_i & ~ack_wbit0_i;

    rx_evt_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    rx_fifo_req u_freq (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_i   (fifo_above_i),
        .fifo_rd_i (fifo_rd_i),
        .ack_i     (ack),
        .req_o     (req_vis)
    );

    assign view = {flags, req_vis};

    rx_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .view_i (view),
        .en_i   (irq_en_i),
        .irq_o  (irq_o)
    );

    assign full_rdata_o = {{RSV_W{1'b0}}, view};
    assign line_rdata_o = {flags[SHR_TOP-1:0], fifo_nonempty_i};

    assert_full_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd_i && evt_vec == '0) |=> (full_rdata_o[FLAG_W-1:1] == '0));
    assert_line_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rd_i && evt_vec == '0) |=> (line_rdata_o[LINE_W-1:1] == '0));
    assert_line_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rd_i && !full_rd_i) |=>
            ((full_rdata_o[FLAG_W-1:LINE_W] & $past(full_rdata_o[FLAG_W-1:LINE_W]))
              == $past(full_rdata_o[FLAG_W-1:LINE_W])));
    assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        full_rdata_o[REG_W-1:FLAG_W] == '0);
endmodule

// File: tb/rx_event_status_bench.sv
`timescale 1ns/1ps
module rx_event_status_bench;
    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:1]  ev;
    logic        above, nonempty, frd, frd_full, lrd, wr, wb0;
    logic [7:0]  en;
    logic [31:0] full_rdata;
    logic [4:0]  line_rdata;
    logic        irq;

    always #(TCK/2) clk = ~clk;

    rx_event_status u_rx_event_status (
        .clk             (clk),
        .rst_n           (rst_n),
        .ev_ctrl_i       (ev[7]),
        .ev_pmatch_i     (ev[6]),
        .ev_brk_end_i    (ev[5]),
        .ev_brk_on_i     (ev[4]),
        .ev_frame_i      (ev[3]),
        .ev_parity_i     (ev[2]),
        .ev_ovr_i        (ev[1]),
        .fifo_above_i    (above),
        .fifo_nonempty_i (nonempty),
        .fifo_rd_i       (frd),
        .full_rd_i       (frd_full),
        .line_rd_i       (lrd),
        .ack_wr_i        (wr),
        .ack_wbit0_i     (wb0),
        .irq_en_i        (en),
        .full_rdata_o    (full_rdata),
        .line_rdata_o    (line_rdata),
        .irq_o           (irq)
    );

    typedef struct {
        string       tag;
        logic [31:0] full;
        logic [4:0]  line;
        logic        irq;
    } exp_t;

    exp_t expq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // stimulus for the next step
    logic [7:1] d_ev;
    logic       d_above, d_nonempty, d_frd, d_srd, d_lrd, d_wr, d_wb0;
    logic [7:0] d_en;

    // reference state built from the requirements
    logic [7:1] m_flags;
    logic       m_req, m_prev, m_irq;

    task automatic step(input string tag);
        exp_t       e;
        logic [7:0] vis;
        logic [7:1] clr;
        @(negedge clk);
        ev = d_ev; above = d_above; nonempty = d_nonempty; frd = d_frd;
        frd_full = d_srd; lrd = d_lrd; wr = d_wr; wb0 = d_wb0; en = d_en;
        vis    = {m_flags, m_req & ~d_frd};
        e.tag  = tag;
        e.full = {24'h0, vis};
        e.line = {m_flags[4:1], d_nonempty};
        e.irq  = m_irq;
        expq.push_back(e);
        // advance the reference by one clock
        m_irq = |(vis & d_en);
        clr   = d_srd ? 7'h7F : (d_lrd ? 7'h0F : 7'h00);
        m_flags = (m_flags & ~clr) | d_ev;
        if (d_above && !m_prev)        m_req = 1'b1;
        else if (!d_above)             m_req = 1'b0;
        else if (d_wr && !d_wb0)       m_req = 1'b0;
        m_prev = d_above;
        d_ev = '0; d_frd = 0; d_srd = 0; d_lrd = 0; d_wr = 0; d_wb0 = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: pop one expectation per cycle and compare
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                n_cmp++;
                if (full_rdata[7:0] !== e.full[7:0]) begin
                    n_bad++;
                    $display("FAIL %s full view: got %h exp %h", e.tag, full_rdata[7:0], e.full[7:0]);
                end
                n_cmp++;
                if (full_rdata[31:8] !== 24'h0) begin
                    n_bad++;
                    $display("FAIL R11 reserved bits: got %h exp 0", full_rdata[31:8]);
                end
                n_cmp++;
                if (line_rdata !== e.line) begin
                    n_bad++;
                    $display("FAIL %s line view: got %h exp %h", e.tag, line_rdata, e.line);
                end
                n_cmp++;
                if (irq !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s R10 irq: got %b exp %b", e.tag, irq, e.irq);
                end
            end
        end
    end

    initial begin
        #(TCK * 200000);
        n_bad++;
        $display("FAIL watchdog expired: got running exp finished");
        summary();
    end

    initial begin
        rst_n = 0;
        ev = '0; above = 0; nonempty = 0; frd = 0; frd_full = 0; lrd = 0;
        wr = 0; wb0 = 0; en = 8'hFF;
        d_ev = '0; d_above = 0; d_nonempty = 0; d_frd = 0; d_srd = 0;
        d_lrd = 0; d_wr = 0; d_wb0 = 0; d_en = 8'hFF;
        m_flags = '0; m_req = 0; m_prev = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        step("R1"); step("R1");

        // R2 / R3: each event alone, then a full read
        for (int b = 1; b < 8; b++) begin
            d_ev[b] = 1'b1; step("R2");
            step("R2"); step("R2");
            d_srd = 1; step("R3");
            step("R3");
        end

        // R4: line read clears only shared flags
        d_ev = 7'h7F; step("R4");
        step("R4");
        d_lrd = 1; step("R4");
        step("R4");
        d_srd = 1; step("R3");
        step("R3");

        // R5: event coincident with clearing reads
        d_ev[3] = 1; d_srd = 1; step("R5");
        step("R5");
        d_ev[2] = 1; d_lrd = 1; step("R5");
        step("R5");
        d_ev[7] = 1; d_lrd = 1; step("R5");
        d_srd = 1; step("R5");
        step("R5");

        // R10: enable gating
        d_en = 8'b0000_1000;
        d_ev[2] = 1; step("R10");
        step("R10"); step("R10");
        d_ev[3] = 1; step("R10");
        step("R10"); step("R10");
        d_srd = 1; step("R10");
        step("R10"); step("R10");
        d_en = 8'hFF;

        // R6: level rise and fall
        d_above = 1; step("R6");
        step("R6"); step("R6");
        d_above = 0; step("R6");
        step("R6"); step("R6");

        // R7: FIFO read masks bit 0
        d_above = 1; step("R7");
        step("R7");
        d_frd = 1; step("R7");
        step("R7"); step("R7");

        // R9: reads leave bit 0 and data-ready alone
        d_srd = 1; step("R9");
        step("R9");
        d_nonempty = 1; d_lrd = 1; step("R9");
        step("R9");

        // R8: acknowledge by writing zero
        d_wr = 1; d_wb0 = 1; step("R8");
        step("R8");
        d_wr = 1; d_wb0 = 0; step("R8");
        step("R8"); step("R8"); step("R8");
        d_above = 0; step("R8");
        d_above = 1; step("R8");
        step("R8"); step("R8");
        d_above = 0; step("R8");
        d_above = 1; d_wr = 1; d_wb0 = 0; step("R8");
        step("R8"); step("R8");

        d_above = 0; d_nonempty = 0;
        step("R6"); step("R6");

        @(negedge clk);
        @(negedge clk);
        #4;
        summary();
    end
endmodule